// File: doc/BRIEF.md
# Muon Transverse Momentum Estimator

This block turns up to three straight track segments into a transverse-momentum estimate. There is one segment from each of three nested muon chambers. Each segment carries a signed position along the chamber (z), a radial position (y), a polar angle (theta) and a valid bit. The block multiplies a curvature-radius estimate by a field-strength constant. The method used depends on how many segments are present.

With all three segments it uses the sagitta of the middle segment. The middle chamber is taken to sit halfway between the outer two, so the sagitta is half of |2·z1 − z0 − z2|. With exactly two segments it uses the bend angle between them and a quarter-wave sine table. With fewer than two it reports no result. A sequential restoring divider forms the final quotient.

A caller pulses `start` while the block is idle. A single-cycle `done` pulse follows with the method code, the momentum code and an overflow flag. These outputs hold their values until the next `done`.

Top module: `muonPtCalc`

## Requirements
- R1: On `start`, the method code is 2 when all three valid bits are set, 1 when exactly two are set, and 0 otherwise. The code appears on `method` with `done`.
- R2: `done` is high for exactly one cycle per accepted `start`. With method 0 the block reports `pt` = 0 and `overflow` = 0.
- R3: For method 2, `pt` = floor(B·(y2−y0)² / (4·|2·z1 − z0 − z2|)), which is B·Δy²/(8·s) with s = |2·z1 − z0 − z2|/2.
- R4: For method 1, the pair is (0,1), (0,2) or (1,2), whichever two are valid. `pt` = floor(B·|Δy|·16383 / (2·S[k])). A quarter turn is 4096 theta counts, and k = min(|Δθ| >> 4, 255). The result lies within 0.5 % + 2 codes of B·|Δy| / (2·sin(k·π/512)).
- R5: Table entry S[k] equals 16383·sin(k·π/512), rounded, for k = 0..255. The bench checks this through the method-1 results of R4.
- R6: For method 2, a zero sagitta gives `pt` = all ones and `overflow` = 1.
- R7: For method 1, a table index of 0 (|Δθ| < 16) gives a zero sine, and then `pt` = all ones and `overflow` = 1.
- R8: A quotient above 2^PT_W − 1 gives `pt` = all ones and `overflow` = 1. Otherwise `overflow` = 0.
- R9: `done` rises no more than 40 cycles after the edge that accepts `start`.
- R10: A `start` pulse that arrives while a computation is in progress is ignored. Input changes after the accepting edge do not alter the result.
- R11: `pt`, `method` and `overflow` change only together with `done`. After reset they read 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation (accepted only when idle) |
| segValid | input | 3 | Per-chamber segment present flags, bit i = chamber i |
| segZ0 | input | POS_W | Chamber 0 position along chamber, signed |
| segZ1 | input | POS_W | Chamber 1 position along chamber, signed |
| segZ2 | input | POS_W | Chamber 2 position along chamber, signed |
| segY0 | input | POS_W | Chamber 0 radial position, signed |
| segY1 | input | POS_W | Chamber 1 radial position, signed |
| segY2 | input | POS_W | Chamber 2 radial position, signed |
| segTh0 | input | ANG_W | Chamber 0 polar angle, signed, 4096 counts per quarter turn |
| segTh1 | input | ANG_W | Chamber 1 polar angle, signed |
| segTh2 | input | ANG_W | Chamber 2 polar angle, signed |
| fieldB | input | B_W | Field-strength constant, unsigned |
| done | output | 1 | One-cycle result strobe |
| method | output | 2 | 0 none, 1 bend angle, 2 sagitta |
| pt | output | PT_W | Momentum code |
| overflow | output | 1 | Result saturated |

## Verification
The bench builds the block with its default parameters: 12-bit positions, 16-bit angles, a 10-bit field constant, a 14-bit sine scale and a 24-bit result. These widths give a 36-bit dividend and a 38-cycle path from start to done, which sits just inside the 40-cycle bound. The 24-bit result limit can be exceeded with a large field constant and a one-count sagitta, so saturation is reached through real quotients as well as through zero divisors. With angles of 6000 counts the table index clamps at its top entry.

// File: rtl/muonPtPkg.sv
package muonPtPkg;

  typedef enum logic [1:0] {
    METH_NONE = 2'd0,
    METH_DEFL = 2'd1,
    METH_SAG  = 2'd2
  } methodE;

  typedef struct packed {
    logic load;
    logic divInit;
    logic divStep;
    logic finish;
  } ctlS;

  typedef struct packed {
    methodE method;
    logic   denZero;
  } statS;

  // Quarter-wave sine entry: round(one * sin(k*pi/2^(idxBits+1))), Q30 Taylor series
  function automatic int sinCode(input int k, input int idxBits, input int one);
    longint qOne, x, x2, t, s;
    qOne = longint'(1) <<< 30;
    x  = (longint'(k) * 64'sd3373259426) / (longint'(2) <<< idxBits);
    x2 = (x * x) >>> 30;
    t  = qOne - x2 / 72;
    t  = qOne - ((x2 * t) >>> 30) / 42;
    t  = qOne - ((x2 * t) >>> 30) / 20;
    t  = qOne - ((x2 * t) >>> 30) / 6;
    s  = (x * t) >>> 30;
    return int'((s * longint'(one) + (longint'(1) <<< 29)) >>> 30);
  endfunction

endpackage

// File: rtl/sinLut.sv
module sinLut #(
  parameter int IDX_W = 8,
  parameter int SIN_W = 14
) (
  input  logic [IDX_W-1:0] idx,
  output logic [SIN_W-1:0] val
);
  import muonPtPkg::*;

  localparam int ENTRIES = 1 << IDX_W;
  localparam int SIN_ONE = (1 << SIN_W) - 1;

  logic [SIN_W-1:0] tbl [ENTRIES];

  for (genvar k = 0; k < ENTRIES; k++) begin : gEntry
    localparam int V = sinCode(k, IDX_W, SIN_ONE);
    assign tbl[k] = SIN_W'(V);
  end

  assign val = tbl[idx];
endmodule

// File: rtl/ptCtrl.sv
module ptCtrl #(
  parameter int NUM_W   = 36,
  parameter int LAT_MAX = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  muonPtPkg::statS  stat,
  output muonPtPkg::ctlS   ctl
);
  import muonPtPkg::*;

  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam int LAT_W = $clog2(LAT_MAX + 1) + 1;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_DIV, S_FIN} stateE;

  stateE            state, nextState;
  logic [CNT_W-1:0] stepCnt;
  logic [LAT_W-1:0] latCnt;

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      S_IDLE: if (start) begin
        ctl.load  = 1'b1;
        nextState = S_CHECK;
      end
      S_CHECK: begin
        if (stat.method == METH_NONE || stat.denZero) nextState = S_FIN;
        else begin
          ctl.divInit = 1'b1;
          nextState   = S_DIV;
        end
      end
      S_DIV: begin
        ctl.divStep = 1'b1;
        if (stepCnt == CNT_W'(NUM_W - 1)) nextState = S_FIN;
      end
      default: begin
        ctl.finish = 1'b1;
        nextState  = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      latCnt  <= '0;
    end else begin
      state <= nextState;
      if (ctl.divInit)      stepCnt <= '0;
      else if (ctl.divStep) stepCnt <= stepCnt + 1'b1;
      if (state == S_IDLE)  latCnt  <= '0;
      else                  latCnt  <= latCnt + 1'b1;
    end
  end

  AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (!rstN) (state != S_IDLE) |-> (latCnt < LAT_W'(LAT_MAX))); // R9
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rstN) (state == S_DIV) |-> (stepCnt < CNT_W'(NUM_W))); // R9
  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN) (state != S_IDLE) |-> !ctl.load); // R10
endmodule

// File: rtl/ptDatapath.sv
module ptDatapath #(
  parameter int POS_W   = 12,
  parameter int ANG_W   = 16,
  parameter int B_W     = 10,
  parameter int SIN_W   = 14,
  parameter int IDX_W   = 8,
  parameter int QTR_LOG = 12,
  parameter int PT_W    = 24,
  parameter int NUM_W   = 36,
  parameter int DEN_W   = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  muonPtPkg::ctlS          ctl,
  output muonPtPkg::statS         stat,
  input  logic [2:0]              segValid,
  input  logic signed [POS_W-1:0] z0, z1, z2,
  input  logic signed [POS_W-1:0] y0, y1, y2,
  input  logic signed [ANG_W-1:0] th0, th1, th2,
  input  logic [B_W-1:0]          fieldB,
  output logic                    done,
  output logic [1:0]              methodOut,
  output logic [PT_W-1:0]         pt,
  output logic                    overflow
);
  import muonPtPkg::*;

  localparam int SIN_ONE = (1 << SIN_W) - 1;

  function automatic logic [POS_W-1:0] posMag(input logic signed [POS_W-1:0] a,
                                               input logic signed [POS_W-1:0] b);
    logic signed [POS_W:0] ae, be, d;
    ae = a;
    be = b;
    d  = ae - be;
    if (d < 0) d = -d;
    return POS_W'(d);
  endfunction

  function automatic logic [ANG_W-1:0] angMag(input logic signed [ANG_W-1:0] a,
                                               input logic signed [ANG_W-1:0] b);
    logic signed [ANG_W:0] ae, be, d;
    ae = a;
    be = b;
    d  = ae - be;
    if (d < 0) d = -d;
    return ANG_W'(d);
  endfunction

  // Method selection
  methodE           methSel;
  logic [1:0]       validCnt;
  always_comb begin
    validCnt = 2'(segValid[0]) + 2'(segValid[1]) + 2'(segValid[2]);
    case (validCnt)
      2'd3:    methSel = METH_SAG;
      2'd2:    methSel = METH_DEFL;
      default: methSel = METH_NONE;
    endcase
  end

  // Sagitta operands
  logic signed [POS_W+1:0] z0e, z1e, z2e, sagD;
  logic [POS_W+1:0]        sagMag;
  logic [POS_W-1:0]        dySag;
  always_comb begin
    z0e    = z0;
    z1e    = z1;
    z2e    = z2;
    sagD   = (z1e <<< 1) - z0e - z2e;
    sagMag = (sagD < 0) ? (POS_W+2)'(-sagD) : (POS_W+2)'(sagD);
    dySag  = posMag(y2, y0);
  end

  // Bend-angle operands: the two valid chambers
  logic signed [POS_W-1:0] yA, yB;
  logic signed [ANG_W-1:0] tA, tB;
  logic [POS_W-1:0]        dyDef;
  logic [ANG_W-1:0]        dTh;
  logic [IDX_W-1:0]        lutIdx;
  logic [SIN_W-1:0]        sinVal;
  always_comb begin
    if (segValid[0] && segValid[1]) begin
      yA = y0; yB = y1; tA = th0; tB = th1;
    end else if (segValid[0] && segValid[2]) begin
      yA = y0; yB = y2; tA = th0; tB = th2;
    end else begin
      yA = y1; yB = y2; tA = th1; tB = th2;
    end
    dyDef = posMag(yA, yB);
    dTh   = angMag(tA, tB);
    if (dTh >= ANG_W'(1 << QTR_LOG)) lutIdx = '1;
    else                             lutIdx = dTh[QTR_LOG-1 -: IDX_W];
  end

  sinLut #(.IDX_W(IDX_W), .SIN_W(SIN_W)) uLut (.idx(lutIdx), .val(sinVal));

  logic [NUM_W-1:0] numNext;
  logic [DEN_W-1:0] denNext;
  always_comb begin
    if (methSel == METH_SAG) begin
      numNext = NUM_W'(fieldB) * NUM_W'(dySag) * NUM_W'(dySag);
      denNext = DEN_W'({sagMag, 2'b00});
    end else begin
      numNext = NUM_W'(fieldB) * NUM_W'(dyDef) * NUM_W'(SIN_ONE);
      denNext = DEN_W'({sinVal, 1'b0});
    end
  end

  // Operand registers and restoring divider
  methodE           methR;
  logic             denZeroR, divActive;
  logic [NUM_W-1:0] quoR;
  logic [DEN_W-1:0] denR, remR;
  logic [DEN_W:0]   remShift;

  assign remShift     = {remR, quoR[NUM_W-1]};
  assign stat.method  = methR;
  assign stat.denZero = denZeroR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      methR     <= METH_NONE;
      denZeroR  <= 1'b0;
      quoR      <= '0;
      denR      <= '0;
      remR      <= '0;
      divActive <= 1'b0;
    end else begin
      if (ctl.load) begin
        methR    <= methSel;
        denZeroR <= (denNext == '0);
        quoR     <= numNext;
        denR     <= denNext;
      end
      if (ctl.divInit) begin
        remR      <= '0;
        divActive <= 1'b1;
      end else if (ctl.divStep) begin
        if (remShift >= {1'b0, denR}) begin
          remR <= DEN_W'(remShift - {1'b0, denR});
          quoR <= {quoR[NUM_W-2:0], 1'b1};
        end else begin
          remR <= DEN_W'(remShift);
          quoR <= {quoR[NUM_W-2:0], 1'b0};
        end
      end
      if (ctl.finish) divActive <= 1'b0;
    end
  end

  // Result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done      <= 1'b0;
      methodOut <= 2'd0;
      pt        <= '0;
      overflow  <= 1'b0;
    end else begin
      done <= ctl.finish;
      if (ctl.finish) begin
        methodOut <= methR;
        if (methR == METH_NONE) begin
          pt       <= '0;
          overflow <= 1'b0;
        end else if (denZeroR || (|quoR[NUM_W-1:PT_W])) begin
          pt       <= '1;
          overflow <= 1'b1;
        end else begin
          pt       <= quoR[PT_W-1:0];
          overflow <= 1'b0;
        end
      end
    end
  end

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rstN) divActive |-> (remR < denR)); // R3
  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rstN) ctl.divInit |-> !denZeroR); // R6
endmodule

// File: rtl/muonPtCalc.sv
module muonPtCalc #(
  parameter int POS_W   = 12,
  parameter int ANG_W   = 16,
  parameter int B_W     = 10,
  parameter int SIN_W   = 14,
  parameter int IDX_W   = 8,
  parameter int QTR_LOG = 12,
  parameter int PT_W    = 24,
  parameter int LAT_MAX = 40
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [2:0]              segValid,
  input  logic signed [POS_W-1:0] segZ0,
  input  logic signed [POS_W-1:0] segZ1,
  input  logic signed [POS_W-1:0] segZ2,
  input  logic signed [POS_W-1:0] segY0,
  input  logic signed [POS_W-1:0] segY1,
  input  logic signed [POS_W-1:0] segY2,
  input  logic signed [ANG_W-1:0] segTh0,
  input  logic signed [ANG_W-1:0] segTh1,
  input  logic signed [ANG_W-1:0] segTh2,
  input  logic [B_W-1:0]          fieldB,
  output logic                    done,
  output logic [1:0]              method,
  output logic [PT_W-1:0]         pt,
  output logic                    overflow
);
  import muonPtPkg::*;

  localparam int NUM_W = B_W + POS_W + ((POS_W > SIN_W) ? POS_W : SIN_W);
  localparam int DEN_W = ((POS_W + 4) > (SIN_W + 1)) ? (POS_W + 4) : (SIN_W + 1);

  ctlS  ctl;
  statS stat;

  ptCtrl #(.NUM_W(NUM_W), .LAT_MAX(LAT_MAX)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat), .ctl(ctl)
  );

  ptDatapath #(
    .POS_W(POS_W), .ANG_W(ANG_W), .B_W(B_W), .SIN_W(SIN_W), .IDX_W(IDX_W),
    .QTR_LOG(QTR_LOG), .PT_W(PT_W), .NUM_W(NUM_W), .DEN_W(DEN_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stat(stat), .segValid(segValid),
    .z0(segZ0), .z1(segZ1), .z2(segZ2), .y0(segY0), .y1(segY1), .y2(segY2),
    .th0(segTh0), .th1(segTh1), .th2(segTh2), .fieldB(fieldB),
    .done(done), .methodOut(method), .pt(pt), .overflow(overflow)
  );

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R2
  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rstN) (done && method == 2'd0) |-> (pt == '0 && !overflow)); // R2
  AST_OVF_SATURATES: assert property (@(posedge clk) disable iff (!rstN) (done && overflow) |-> (&pt)); // R8
  AST_METHOD_CODE: assert property (@(posedge clk) disable iff (!rstN) done |-> (method != 2'd3)); // R1
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN) !done |-> ($stable(pt) && $stable(method) && $stable(overflow))); // R11
endmodule

// File: tb/tb_muonPtCalc.sv
`timescale 1ns/1ps
module tb_muonPtCalc;
  localparam int PT_W   = 24;
  localparam longint PT_MAX = (longint'(1) << PT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] vIn = 3'b000;
  int zIn [3];
  int yIn [3];
  int tIn [3];
  int bIn = 0;
  logic done, overflow;
  logic [1:0] method;
  logic [PT_W-1:0] pt;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  int gotCyc;
  longint gotPt;
  int gotMeth;
  bit gotOvf;

  always #2.5 clk = ~clk;

  muonPtCalc dut (
    .clk(clk), .rstN(rstN), .start(start), .segValid(vIn),
    .segZ0(zIn[0][11:0]), .segZ1(zIn[1][11:0]), .segZ2(zIn[2][11:0]),
    .segY0(yIn[0][11:0]), .segY1(yIn[1][11:0]), .segY2(yIn[2][11:0]),
    .segTh0(tIn[0][15:0]), .segTh1(tIn[1][15:0]), .segTh2(tIn[2][15:0]),
    .fieldB(bIn[9:0]), .done(done), .method(method), .pt(pt), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setSeg(input logic [2:0] v, input int z0, z1, z2, y0, y1, y2,
                        input int t0, t1, t2, input int b);
    vIn = v; zIn[0] = z0; zIn[1] = z1; zIn[2] = z2;
    yIn[0] = y0; yIn[1] = y1; yIn[2] = y2;
    tIn[0] = t0; tIn[1] = t1; tIn[2] = t2; bIn = b;
  endtask

  // Pulse start, optionally re-pulse with scrambled inputs while busy
  task automatic run(input bit disturb);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    gotCyc = 1;
    while (!done && gotCyc < 60) begin
      @(negedge clk);
      gotCyc++;
      if (disturb && gotCyc == 5) begin
        setSeg(3'b011, 7, 9, 11, 100, -100, 5, 1000, -1000, 0, 999);
        start = 1'b1;
      end
      if (disturb && gotCyc == 6) start = 1'b0;
    end
    gotPt = longint'(pt); gotMeth = int'(method); gotOvf = overflow;
    chk(gotCyc <= 40, "R9 latency", gotCyc, 40);
    @(negedge clk);
    chk(done == 1'b0, "R2 done single cycle", done, 0);
    chk(longint'(pt) == gotPt, "R11 result held", longint'(pt), gotPt);
  endtask

  function automatic longint iabs(input longint a);
    return (a < 0) ? -a : a;
  endfunction

  task automatic testSagitta(input int z0, z1, z2, y0, y2, b, input string tag);
    longint num, den, exp;
    setSeg(3'b111, z0, z1, z2, y0, 50, y2, 100, 200, 300, b);
    run(1'b0);
    num = longint'(b) * iabs(y2 - y0) * iabs(y2 - y0);
    den = 4 * iabs(2 * z1 - z0 - z2);
    chk(gotMeth == 2, "R1 three segments give method 2", gotMeth, 2);
    if (den == 0) begin
      chk(gotPt == PT_MAX && gotOvf, "R6 zero sagitta saturates", gotPt, PT_MAX);
    end else begin
      exp = num / den;
      if (exp > PT_MAX) chk(gotPt == PT_MAX && gotOvf, "R8 quotient overflow", gotPt, PT_MAX);
      else chk(gotPt == exp && !gotOvf, tag, gotPt, exp);
    end
  endtask

  task automatic testDeflect(input logic [2:0] v, input int ya, yb, ta, tb, b, input string tag);
    int ys[3]; int ts[3]; int ia; int ib; int k; longint dth;
    real expR; real tol; longint diff;
    ys = '{0, 0, 0}; ts = '{0, 0, 0};
    ia = v[0] ? 0 : 1;
    ib = v[2] ? 2 : 1;
    ys[ia] = ya; ys[ib] = yb; ts[ia] = ta; ts[ib] = tb;
    setSeg(v, 11, 22, 33, ys[0], ys[1], ys[2], ts[0], ts[1], ts[2], b);
    run(1'b0);
    chk(gotMeth == 1, "R1 two segments give method 1", gotMeth, 1);
    dth = iabs(ta - tb);
    k = (dth >= 4096) ? 255 : int'(dth >> 4);
    if (k == 0) begin
      chk(gotPt == PT_MAX && gotOvf, "R7 zero sine saturates", gotPt, PT_MAX);
    end else begin
      expR = real'(b) * real'(iabs(ya - yb)) / (2.0 * $sin(real'(k) * 3.14159265358979 / 512.0));
      tol  = expR / 200.0 + 2.0;
      diff = iabs(gotPt - longint'(expR));
      chk(real'(diff) <= tol && !gotOvf, tag, gotPt, longint'(expR));
    end
  endtask

  task automatic testNone(input logic [2:0] v);
    setSeg(v, 5, 6, 7, 100, 200, 300, 10, 500, 900, 300);
    run(1'b0);
    chk(gotMeth == 0, "R1 fewer than two gives method 0", gotMeth, 0);
    chk(gotPt == 0 && !gotOvf, "R2 no result reports zero", gotPt, 0);
  endtask

  task automatic testBusy();
    longint exp;
    setSeg(3'b111, -500, -700, -300, 300, 0, -900, 0, 0, 0, 77);
    exp = longint'(77) * 1200 * 1200 / 2400;
    run(1'b1);
    chk(gotPt == exp && gotMeth == 2, "R10 start ignored while busy", gotPt, exp);
    repeat (45) @(negedge clk);
    chk(longint'(pt) == exp && method == 2'd2, "R10 no second result", longint'(pt), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    setSeg(3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(done == 0 && pt == 0 && method == 0 && overflow == 0, "R11 reset state", longint'(pt), 0);

    testSagitta(100, 160, 200, -1000, 1000, 200, "R3 sagitta value A");
    testSagitta(-500, -700, -300, 300, -900, 77, "R3 sagitta value B");
    testSagitta(10, 20, 30, -800, 900, 500, "R6 zero sagitta");
    testSagitta(0, 1, 1, -2000, 2000, 1023, "R8 overflow");
    testDeflect(3'b101, 100, 1900, 1000, 200, 300, "R4 pair 0-2 R5 table");
    testDeflect(3'b110, -700, 1200, -2000, 1500, 511, "R4 pair 1-2 R5 table");
    testDeflect(3'b011, 2000, -1500, -3000, 3000, 1000, "R4 pair 0-1 clamped index");
    testDeflect(3'b011, 400, -400, 40, 50, 100, "R7 small angle");
    testNone(3'b001);
    testNone(3'b000);
    testBusy();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule